// File: doc/BRIEF.md
# Sixteen-Pin Edge-Interrupt GPIO Port

This block is a general-purpose I/O port with sixteen pins. Software drives it through a small register interface. A direction register sets each pin as an input or an output. An output latch supplies the value for the pins set as outputs. Each clock the block samples the pin inputs, which must already be synchronized, into a register.

Each pin has a polarity bit that picks which edge counts as an event: a rising edge or a falling edge. A qualifying event sets a sticky status bit. Software clears status bits by writing ones to them. A single registered interrupt line stays high while any status bit is set. A pin-control register acts as a gate on the readback of the sampled inputs.

Top module: `edge_gpio_port`

## Requirements
- R1: After reset, reads return the following values. Input data is 0x0000 and status is 0x0000. Output latch, direction, edge select, mask and pin control are all 0xFFFF. Outputs are irq=0, pin_oe=0x0000 and pin_out=0x0000.
- R2: pin_oe bit i is 1 exactly when direction bit i is 0, so direction 1 means input. pin_out bit i carries output latch bit i while direction bit i is 0 and is 0 otherwise.
- R3: A pin whose edge-select bit is 1 records an event when its sampled value goes from 0 to 1.
- R4: A pin whose edge-select bit is 0 records an event when its sampled value goes from 1 to 0. A rise on such a pin records nothing.
- R5: An event sets its status bit only when the pin's direction bit is 1 and its mask bit is 0.
- R6: Writing to status (offset 0x14) clears every bit written as 1 and leaves the other bits unchanged. irq stays 1 while any status bit remains set and falls only after all status bits are 0.
- R7: A read of input data (offset 0x00) returns the sampled inputs ANDed with pin control (offset 0x18).
- R8: Writes to offset 0x00 change no state. Reads of any offset outside 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 return 0.
- R9: A pin change that is present before a clock edge sets the status bit at that edge. irq rises at the following edge. After status becomes 0, irq falls one edge later.
- R10: The output latch (0x04), direction (0x08), edge select (0x0C), mask (0x10) and pin control (0x18) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the read |
| pin_in | input | 16 | Synchronized pin levels |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The hardest case to reach from the ports is a partial clear: two status bits are set, one of them is cleared, and irq must stay high. To reach it, the stimulus unmasks two pins and raises both in the same cycle. It then clears the status bits one at a time and checks irq after each write. A second hard case is an edge that must not count, because the pin is an output, the pin is masked, or the edge has the wrong polarity. The stimulus creates each such edge and then reads status back to confirm it stayed 0.

// File: rtl/edge_gpio_port.sv
module edge_gpio_port #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_IN   = AW'(8'h00);
  localparam logic [AW-1:0] A_OUT  = AW'(8'h04);
  localparam logic [AW-1:0] A_DIR  = AW'(8'h08);
  localparam logic [AW-1:0] A_POL  = AW'(8'h0C);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h10);
  localparam logic [AW-1:0] A_STS  = AW'(8'h14);
  localparam logic [AW-1:0] A_GATE = AW'(8'h18);

  logic [W-1:0] in_q, out_q, dir_q, pol_q, msk_q, sts_q, gate_q;
  logic [W-1:0] rise, fall, evt, clr;
  logic         wr;

  assign wr   = bus_valid && bus_write;
  assign rise = pin_in & ~in_q;
  assign fall = ~pin_in & in_q;
  assign evt  = ((pol_q & rise) | (~pol_q & fall)) & dir_q & ~msk_q;
  assign clr  = (wr && bus_addr == A_STS) ? bus_wdata : '0;

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q & ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      out_q  <= '1;
      dir_q  <= '1;
      pol_q  <= '1;
      msk_q  <= '1;
      gate_q <= '1;
      sts_q  <= '0;
      irq    <= 1'b0;
    end else begin
      in_q  <= pin_in;
      sts_q <= (sts_q & ~clr) | evt;
      irq   <= |sts_q;
      if (wr) begin
        case (bus_addr)
          A_OUT:  out_q  <= bus_wdata;
          A_DIR:  dir_q  <= bus_wdata;
          A_POL:  pol_q  <= bus_wdata;
          A_MSK:  msk_q  <= bus_wdata;
          A_GATE: gate_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_IN:   bus_rdata = in_q & gate_q;
        A_OUT:  bus_rdata = out_q;
        A_DIR:  bus_rdata = dir_q;
        A_POL:  bus_rdata = pol_q;
        A_MSK:  bus_rdata = msk_q;
        A_STS:  bus_rdata = sts_q;
        A_GATE: bus_rdata = gate_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  p_qualified_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q)) & ~$past(dir_q & ~msk_q)) == '0);

  p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q != '0) |=> irq);

  p_oe_only_by_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != $past(pin_oe)) |-> $past(wr && bus_addr == A_DIR));

  p_in_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_IN) |=> ($stable(out_q) && $stable(dir_q) &&
      $stable(pol_q) && $stable(msk_q) && $stable(gate_q)));
endmodule

// File: tb/edge_gpio_port_tb.sv
module edge_gpio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int total = 0;
  int bad = 0;

  edge_gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    bus_valid = 1'b0;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rd("R1 in", 8'h00, 16'h0000);
    rd("R1 out", 8'h04, 16'hFFFF);
    rd("R1 dir", 8'h08, 16'hFFFF);
    rd("R1 pol", 8'h0C, 16'hFFFF);
    rd("R1 mask", 8'h10, 16'hFFFF);
    rd("R1 status", 8'h14, 16'h0000);
    rd("R1 gate", 8'h18, 16'hFFFF);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 pin_out", pin_out, 16'h0000);
  endtask

  task automatic t_dir;
    wr(8'h08, 16'h00FF);
    #1 chk("R2 oe", pin_oe, 16'hFF00);
    chk("R2 pin_out latch ones", pin_out, 16'hFF00);
    wr(8'h04, 16'h1234);
    #1 chk("R2 pin_out", pin_out, 16'h1200);
    rd("R10 out", 8'h04, 16'h1234);
    rd("R10 dir", 8'h08, 16'h00FF);
    wr(8'h08, 16'hFFFF);
    #1 chk("R2 oe off", pin_oe, 16'h0000);
  endtask

  task automatic t_rise;
    wr(8'h10, 16'hFFFE);
    rd("R10 mask", 8'h10, 16'hFFFE);
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); #1;
    rd("R3 status rise", 8'h14, 16'h0001);
    chk("R9 irq not yet", {15'd0, irq}, 16'h0000);
    @(posedge clk); #1;
    chk("R9 irq raised", {15'd0, irq}, 16'h0001);
    wr(8'h14, 16'h0001);
    chk("R9 irq lags clear", {15'd0, irq}, 16'h0001);
    @(posedge clk); #1;
    chk("R6 irq dropped", {15'd0, irq}, 16'h0000);
    rd("R6 status cleared", 8'h14, 16'h0000);
  endtask

  task automatic t_fall;
    wr(8'h0C, 16'hFFFD);
    rd("R10 pol", 8'h0C, 16'hFFFD);
    wr(8'h10, 16'hFFFD);
    set_pins(pin_in | 16'h0002);
    @(posedge clk); #1;
    rd("R4 rise ignored", 8'h14, 16'h0000);
    set_pins(pin_in & ~16'h0002);
    rd("R4 status fall", 8'h14, 16'h0002);
    wr(8'h14, 16'hFFFF);
    wr(8'h0C, 16'hFFFF);
  endtask

  task automatic t_qual;
    wr(8'h10, 16'hFFF7);
    wr(8'h08, 16'hFFF7);
    set_pins(pin_in | 16'h000C);
    @(posedge clk); #1;
    rd("R5 masked or output", 8'h14, 16'h0000);
    chk("R5 irq quiet", {15'd0, irq}, 16'h0000);
    wr(8'h08, 16'hFFFF);
    wr(8'h10, 16'hFFFF);
  endtask

  task automatic t_partial;
    wr(8'h10, 16'hFFCF);
    set_pins(pin_in | 16'h0030);
    rd("R6 two set", 8'h14, 16'h0030);
    wr(8'h14, 16'h0010);
    @(posedge clk); #1;
    rd("R6 one left", 8'h14, 16'h0020);
    chk("R6 irq held", {15'd0, irq}, 16'h0001);
    wr(8'h14, 16'h0020);
    @(posedge clk); #1;
    chk("R6 irq low", {15'd0, irq}, 16'h0000);
    wr(8'h10, 16'hFFFF);
  endtask

  task automatic t_inread;
    set_pins(16'hA5A5);
    rd("R7 full gate", 8'h00, 16'hA5A5);
    wr(8'h18, 16'h0F0F);
    rd("R10 gate", 8'h18, 16'h0F0F);
    rd("R7 gated", 8'h00, 16'h0505);
    wr(8'h00, 16'h0000);
    rd("R8 in write ignored", 8'h00, 16'h0505);
    rd("R8 out unchanged", 8'h04, 16'h1234);
    rd("R8 unmapped 1C", 8'h1C, 16'h0000);
    rd("R8 unmapped 02", 8'h02, 16'h0000);
    rd("R8 unmapped FC", 8'hFC, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_dir();
    t_rise();
    t_fall();
    t_qual();
    t_partial();
    t_inread();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule